// File: doc/BRIEF.md
# Complex Radix-2 Butterfly with Static Scaling

This block is the arithmetic core of one stage of a streaming decimation-in-time FFT. Each clock it can accept two complex operands, `u` and `v`, and a complex twiddle factor `w`. It returns the sum `x = u + t` and the difference `y = u - t`, where `t` is the rounded product `v * w`. Both parts of every value are 12-bit signed two's complement. The twiddle has 11 fraction bits.

A compile-time parameter `SCALE` sets a power-of-two divisor. When `SCALE` is 1 the outputs wrap in the 12-bit word. When `SCALE` is larger, the full-precision sum and difference are shifted right arithmetically by log2(`SCALE`) before they are cut back to 12 bits. A chain of stages can therefore halve its growth at every stage and avoid overflow.

The datapath has two register stages, and a valid flag travels with the data. Stage sequencing, data buffering and twiddle generation belong to the surrounding stage logic.

Top module: `cbfly_r2`

## Requirements
- R1: The product is formed as t.re = vr*wr - vi*wi and t.im = vr*wi + vi*wr at full precision. Each part is rounded by adding 2^10, shifting right arithmetically by 11, and keeping the low 12 bits, so an exact half rounds toward plus infinity. A zero `v` gives a zero product.
- R2: For every accepted input the block returns x = u + t and y = u - t, for both the real and the imaginary parts.
- R3: With `SCALE` = 1 the sum and difference keep only their low 12 bits (two's-complement wrap). In that case x + y equals 2u modulo 2^12.
- R4: With `SCALE` > 1 the 13-bit sum and difference are arithmetic-shifted right by log2(`SCALE`) and then cut to 12 bits.
- R5: `out_valid` and the result for an input sampled with `in_valid` high appear exactly two rising edges later. Results leave in input order, and back-to-back inputs give back-to-back results.
- R6: While `out_valid` is low, all four result outputs hold their previous values, whatever is driven on the data inputs.
- R7: While `rst_n` is low at a rising edge, `out_valid` and all result outputs become zero.
- R8: A twiddle of real -2048 (that is, -1.0) and imaginary 0 gives t = -v, with the negation wrapping in 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on the data inputs are accepted |
| u_re | input | 12 | Operand u, real part |
| u_im | input | 12 | Operand u, imaginary part |
| v_re | input | 12 | Operand v, real part |
| v_im | input | 12 | Operand v, imaginary part |
| w_re | input | 12 | Twiddle, real part, 11 fraction bits |
| w_im | input | 12 | Twiddle, imaginary part, 11 fraction bits |
| out_valid | output | 1 | Result outputs carry a new result |
| x_re | output | 12 | Sum output, real part |
| x_im | output | 12 | Sum output, imaginary part |
| y_re | output | 12 | Difference output, real part |
| y_im | output | 12 | Difference output, imaginary part |

## Verification
The embedded properties check the following on every cycle:
- the two-edge valid latency;
- that results hold while no result is valid;
- that a zero `v` and a minus-one twiddle give the known products;
- that the unscaled sum and difference always add to twice `u`.

Exact bit-level values cannot be written as a single property. This covers rounding ties, wrap on overflow, the shifted values of a scaled instance, and output ordering under gapped and back-to-back traffic. These are shown only by the bench scenarios. The bench compares a default instance and a `SCALE` = 4 instance against an independent arithmetic model.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;
    localparam int DATA_W    = 12;
    localparam int TWID_W    = 12;
    localparam int TWID_FRAC = 11;
    localparam int PROD_W    = DATA_W + TWID_W + 1;
    localparam int SUM_W     = DATA_W + 1;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWID_W-1:0] re;
        logic signed [TWID_W-1:0] im;
    } twid_t;

    typedef struct packed {
        logic  vld;
        cplx_t u;
        cplx_t t;
    } mul_stage_t;

    typedef struct packed {
        logic  vld;
        cplx_t x;
        cplx_t y;
    } sum_stage_t;

    // round half up at the twiddle binary point, then keep the data word
    function automatic logic signed [DATA_W-1:0] round_prod(input logic signed [PROD_W-1:0] p);
        logic signed [PROD_W-1:0] r;
        r = p + PROD_W'(1 << (TWID_FRAC - 1));
        return DATA_W'(r >>> TWID_FRAC);
    endfunction
endpackage

// File: rtl/cbfly_cmul.sv
module cbfly_cmul
    import cbfly_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  cplx_t      u_in,
    input  cplx_t      v_in,
    input  twid_t      w_in,
    output mul_stage_t st_q
);
    mul_stage_t st_d;

    always_comb begin
        logic signed [PROD_W-1:0] vr, vi, wr, wi;
        vr = PROD_W'(v_in.re);
        vi = PROD_W'(v_in.im);
        wr = PROD_W'(w_in.re);
        wi = PROD_W'(w_in.im);
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.u    = u_in;
            st_d.t.re = round_prod(vr * wr - vi * wi);
            st_d.t.im = round_prod(vr * wi + vi * wr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: zero operand v rounds to a zero product
    a_r1_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && v_in == '0) |=> (st_q.t == '0));

    // R8: twiddle of -1.0 negates v with 12-bit wrap
    a_r8_neg_twiddle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && w_in.re == TWID_W'(1 << (TWID_W - 1)) && w_in.im == '0)
        |=> (st_q.t.re == DATA_W'(-$past(v_in.re)) && st_q.t.im == DATA_W'(-$past(v_in.im))));
endmodule

// File: rtl/cbfly_addsub.sv
module cbfly_addsub
    import cbfly_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  mul_stage_t s_in,
    output sum_stage_t st_q
);
    sum_stage_t st_d;

    always_comb begin
        logic signed [SUM_W-1:0] sr, si, dr, di;
        sr = SUM_W'(s_in.u.re) + SUM_W'(s_in.t.re);
        si = SUM_W'(s_in.u.im) + SUM_W'(s_in.t.im);
        dr = SUM_W'(s_in.u.re) - SUM_W'(s_in.t.re);
        di = SUM_W'(s_in.u.im) - SUM_W'(s_in.t.im);
        st_d     = st_q;
        st_d.vld = s_in.vld;
        if (s_in.vld) begin
            st_d.x.re = DATA_W'(sr >>> SHIFT);
            st_d.x.im = DATA_W'(si >>> SHIFT);
            st_d.y.re = DATA_W'(dr >>> SHIFT);
            st_d.y.im = DATA_W'(di >>> SHIFT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: results hold while nothing new is valid
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld |-> ($stable(st_q.x) && $stable(st_q.y)));

    generate
        if (SHIFT == 0) begin : g_wrap_chk
            // R3: unscaled sum plus difference is twice u modulo the word
            a_r3_wrap_sum: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.vld |->
                    (DATA_W'(st_q.x.re + st_q.y.re) == DATA_W'({$past(s_in.u.re), 1'b0}) &&
                     DATA_W'(st_q.x.im + st_q.y.im) == DATA_W'({$past(s_in.u.im), 1'b0})));
        end
    endgenerate
endmodule

// File: rtl/cbfly_r2.sv
module cbfly_r2
    import cbfly_pkg::*;
#(
    parameter int SCALE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] u_re,
    input  logic signed [DATA_W-1:0] u_im,
    input  logic signed [DATA_W-1:0] v_re,
    input  logic signed [DATA_W-1:0] v_im,
    input  logic signed [TWID_W-1:0] w_re,
    input  logic signed [TWID_W-1:0] w_im,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] x_re,
    output logic signed [DATA_W-1:0] x_im,
    output logic signed [DATA_W-1:0] y_re,
    output logic signed [DATA_W-1:0] y_im
);
    localparam int SHIFT = $clog2(SCALE);

    generate
        if ((SCALE < 1) || ((SCALE & (SCALE - 1)) != 0)) begin : g_bad_scale
            $error("cbfly_r2: SCALE must be a power of two");
        end
    endgenerate

    cplx_t      u_c, v_c;
    twid_t      w_c;
    mul_stage_t mul_q;
    sum_stage_t sum_q;

    always_comb begin
        u_c = '{re: u_re, im: u_im};
        v_c = '{re: v_re, im: v_im};
        w_c = '{re: w_re, im: w_im};
    end

    cbfly_cmul u_cmul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .u_in     (u_c),
        .v_in     (v_c),
        .w_in     (w_c),
        .st_q     (mul_q)
    );

    cbfly_addsub #(.SHIFT(SHIFT)) u_addsub (
        .clk   (clk),
        .rst_n (rst_n),
        .s_in  (mul_q),
        .st_q  (sum_q)
    );

    assign out_valid = sum_q.vld;
    assign x_re      = sum_q.x.re;
    assign x_im      = sum_q.x.im;
    assign y_re      = sum_q.y.re;
    assign y_im      = sum_q.y.im;

    // edges since reset, saturating, so the latency check never looks before reset
    logic [1:0] since_rst_d, since_rst_q;
    always_comb since_rst_d = (since_rst_q == 2'd2) ? since_rst_q : since_rst_q + 2'd1;
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst_q <= '0;
        else        since_rst_q <= since_rst_d;
    end

    // R5: valid appears exactly two edges after acceptance
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/cbfly_r2_bench.sv
`timescale 1ns/1ps
module cbfly_r2_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] u_re = '0, u_im = '0, v_re = '0, v_im = '0, w_re = '0, w_im = '0;
    logic out_valid, out_valid4;
    logic signed [11:0] x_re, x_im, y_re, y_im;
    logic signed [11:0] x_re4, x_im4, y_re4, y_im4;

    always #2.5 clk = ~clk;

    cbfly_r2 u_cbfly_r2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .u_re(u_re), .u_im(u_im), .v_re(v_re), .v_im(v_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im));

    cbfly_r2 #(.SCALE(4)) u_cbfly_r2_s4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .u_re(u_re), .u_im(u_im), .v_re(v_re), .v_im(v_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid4), .x_re(x_re4), .x_im(x_im4), .y_re(y_re4), .y_im(y_im4));

    typedef struct {
        int    r[8];
        int    cyc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc_cnt = 0;
    int   last[8];
    bit   done = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd_prod(input int a, input int b, input int c, input int d, input bit add);
        int p;
        p = add ? (a * b + c * d) : (a * b - c * d);
        p = (p + 1024) >>> 11;
        return int'($signed(p[11:0]));
    endfunction

    function automatic int fit(input int s, input int sh);
        int r;
        r = s >>> sh;
        return int'($signed(r[11:0]));
    endfunction

    task automatic send(input int ur, input int ui, input int vr, input int vi,
                        input int wr, input int wi, input string tag);
        exp_t e;
        int tr, ti;
        @(posedge clk); #1;
        u_re = 12'(ur); u_im = 12'(ui); v_re = 12'(vr); v_im = 12'(vi);
        w_re = 12'(wr); w_im = 12'(wi);
        in_valid = 1'b1;
        tr = rnd_prod(int'(v_re), int'(w_re), int'(v_im), int'(w_im), 1'b0);
        ti = rnd_prod(int'(v_re), int'(w_im), int'(v_im), int'(w_re), 1'b1);
        e.r[0] = fit(int'(u_re) + tr, 0);
        e.r[1] = fit(int'(u_im) + ti, 0);
        e.r[2] = fit(int'(u_re) - tr, 0);
        e.r[3] = fit(int'(u_im) - ti, 0);
        e.r[4] = fit(int'(u_re) + tr, 2);
        e.r[5] = fit(int'(u_im) + ti, 2);
        e.r[6] = fit(int'(u_re) - tr, 2);
        e.r[7] = fit(int'(u_im) - ti, 2);
        e.cyc  = cyc_cnt;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            u_re = 12'($urandom); v_re = 12'($urandom); w_re = 12'($urandom);
            u_im = 12'($urandom); v_im = 12'($urandom); w_im = 12'($urandom);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        int act[8];
        act = '{int'(x_re), int'(x_im), int'(y_re), int'(y_im),
                int'(x_re4), int'(x_im4), int'(y_re4), int'(y_im4)};
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) last[i] = 0;
        end else if (cyc_cnt > 0 && !done) begin
            chk(out_valid == out_valid4, "R5 instances agree on valid", out_valid4, out_valid);
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 result without input", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc_cnt == e.cyc + 2, {"R5 latency ", e.tag}, cyc_cnt - e.cyc, 2);
                    for (int i = 0; i < 4; i++)
                        chk(act[i] == e.r[i], {e.tag, " unscaled"}, act[i], e.r[i]);
                    for (int i = 4; i < 8; i++)
                        chk(act[i] == e.r[i], {"R4 scaled ", e.tag}, act[i], e.r[i]);
                end
            end else begin
                for (int i = 0; i < 8; i++)
                    chk(act[i] == last[i], "R6 hold while not valid", act[i], last[i]);
            end
            for (int i = 0; i < 8; i++) last[i] = act[i];
        end
    end

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog actual=hung expected=drained");
        summary();
    end

    initial begin
        // R7: drive garbage with valid during reset, outputs must be zero
        in_valid = 1'b1; u_re = 12'sd700; v_re = 12'sd300; w_re = 12'sd1000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_valid4 == 1'b0, "R7 reset valid", out_valid, 0);
        chk(x_re == 0 && x_im == 0 && y_re == 0 && y_im == 0, "R7 reset data", x_re, 0);
        chk(x_re4 == 0 && y_im4 == 0, "R7 reset data scaled", x_re4, 0);
        in_valid = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 rounding ties and zero operand
        send(0, 0, 1, 0, 1024, 0, "R1 half rounds up");
        send(0, 0, -1, 0, 1024, 0, "R1 negative half to zero");
        send(5, -7, 0, 0, 1500, -900, "R1 zero v");
        send(0, 0, 3, -5, 700, 1300, "R1 complex mix");
        idle(3);
        // R8 minus-one twiddle, including the wrapping corner
        send(10, 20, 300, -400, -2048, 0, "R8 neg twiddle");
        send(0, 0, -2048, 2047, -2048, 0, "R8 neg twiddle wrap");
        idle(1);
        // R3 overflow wrap
        send(2047, -2048, 1000, -1000, -2048, 0, "R3 overflow wrap");
        send(2047, 2047, 2047, 2047, 2047, 2047, "R3 large operands");
        send(-2048, -2048, -2048, -2048, 2047, -2048, "R3 negative extreme");
        idle(2);
        // R2 random, back-to-back then gapped
        for (int i = 0; i < 200; i++)
            send(int'($signed(12'($urandom))), int'($signed(12'($urandom))),
                 int'($signed(12'($urandom))), int'($signed(12'($urandom))),
                 int'($signed(12'($urandom))), int'($signed(12'($urandom))), "R2 random burst");
        for (int i = 0; i < 100; i++) begin
            send(int'($signed(12'($urandom))), int'($signed(12'($urandom))),
                 int'($signed(12'($urandom))), int'($signed(12'($urandom))),
                 int'($signed(12'($urandom))), int'($signed(12'($urandom))), "R2 random gapped");
            idle(int'($urandom_range(1, 3)));
        end
        idle(6);
        chk(q.size() == 0, "R5 all results drained", q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule